// File: doc/BRIEF.md
# Oversampling Serial Receiver with Per-Character Status Queue

This block is the receive half of an asynchronous serial channel. It watches one serial input line, finds the falling edge of a start bit, confirms it half a bit later, and assembles the character with one sample taken in the middle of each bit. The line is sampled on a 16x sample-tick input. Configuration inputs pick 7 or 8 data bits and, on top of that, no parity, even parity or odd parity. A single stop bit follows.

A finished character and its flags wait in a holding stage. From there they move into two 4-entry queues that always stay the same depth: one for data and one for status. The status entry records parity error, framing error, overrun and break for that character. Because the holding stage keeps a character while the queues are full, the receiver can store five characters before anything is lost.

Software reads the oldest character and its flags from the read port. A read strobe whose address matches this channel's data address removes one entry from both queues at once. The channel's address is 08h plus the channel-number parameter.

Top module: `serial_rx_stat`

## Requirements
- R1: After reset, rx_avail is 0, rd_data is 00h and all four status outputs are 0.
- R2: A frame is one low start bit, 8 data bits (cfg_eight=1) or 7 data bits (cfg_eight=0) sent LSB first, an optional parity bit and one stop bit. Each bit lasts 16 sample ticks and is sampled at mid-bit. In 7-bit mode, bit 7 of the stored data is 0.
- R3: A low pulse on the line that is shorter than half a bit is not taken as a start bit, and no character is stored.
- R4: With cfg_par_en=1, rd_perr is 1 when the count of ones in the data bits plus the parity bit is odd (cfg_par_odd=0) or even (cfg_par_odd=1). With cfg_par_en=0, rd_perr is always 0.
- R5: rd_ferr is 1 when the stop bit samples low. After such a frame, the receiver waits for the line to return high before it looks for a new start bit.
- R6: rd_brk is 1 when every data bit, the parity bit (if enabled) and the stop bit sample low. A break character therefore also has rd_ferr set.
- R7: Characters come out in the order they arrived. The queues hold 4 entries, and a fifth completed character waits in the holding stage until a slot frees up.
- R8: If a character completes while the holding stage is still occupied, that new character is discarded and the held character gets rd_ovr=1.
- R9: A read strobe with rd_addr equal to 08h+CHAN, while a character is present, removes data and status together. A strobe at any other address changes nothing.
- R10: A read while the queue is empty leaves rd_data and the status outputs at the last character removed, and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rx_line | input | 1 | Serial input, idle high |
| cfg_eight | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address; removes an entry only when it equals 08h+CHAN |
| rx_avail | output | 1 | At least one character is queued |
| rd_data | output | 8 | Oldest character |
| rd_perr | output | 1 | Parity error of the oldest character |
| rd_ferr | output | 1 | Framing error of the oldest character |
| rd_ovr | output | 1 | Overrun flag of the oldest character |
| rd_brk | output | 1 | Break flag of the oldest character |

## Verification
Random characters run across all six format combinations, with occasional inverted parity bits and low stop bits, and reads come at random moments. This shows whether bit order, width masking and each flag are decoded independently of the others. Directed cases cover the rest. An all-zero frame separates break from a plain framing error. A short low glitch checks that a false start is rejected. Six characters sent with no reads show exactly where the holding stage ends and overrun begins. Reads at the wrong address and reads of an empty queue confirm that neither of them moves any state.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic ovr;
    logic ferr;
    logic perr;
  } rx_stat_t;

  // 1 when the parity bit disagrees with the selected sense
  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic pbit, input logic odd);
    return (^d) ^ pbit ^ odd;
  endfunction

  function automatic logic [7:0] chan_addr(input int unsigned ch);
    return 8'h08 + ch[7:0];
  endfunction
endpackage

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              cfg_eight,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output rx_stat_t          stat
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} fst_t;

  fst_t              st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] sh;
  logic              pbit, allz;
  logic [1:0]        sync;
  logic              rx_s;
  logic [IW-1:0]     last_idx;

  assign rx_s     = sync[1];
  assign last_idx = cfg_eight ? IW'(DATA_W-1) : IW'(DATA_W-2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rx};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; sh <= '0;
      pbit <= 1'b0; allz <= 1'b0; done <= 1'b0;
      dout <= '0; stat <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rx_s) begin st <= S_START; cnt <= '0; end
          S_START:
            if (cnt == CW'(HALF-1)) begin
              cnt <= '0;
              if (!rx_s) begin st <= S_DATA; idx <= '0; sh <= '0; allz <= 1'b1; end
              else st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_DATA:
            if (cnt == CW'(OSR-1)) begin
              cnt     <= '0;
              sh[idx] <= rx_s;
              allz    <= allz & ~rx_s;
              if (idx == last_idx) st <= cfg_par_en ? S_PAR : S_STOP;
              else idx <= idx + 1'b1;
            end else cnt <= cnt + 1'b1;
          S_PAR:
            if (cnt == CW'(OSR-1)) begin
              cnt <= '0; pbit <= rx_s; allz <= allz & ~rx_s; st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          S_STOP:
            if (cnt == CW'(OSR-1)) begin
              cnt       <= '0;
              done      <= 1'b1;
              dout      <= sh;
              stat.perr <= cfg_par_en & parity_bad(sh, pbit, cfg_par_odd);
              stat.ferr <= ~rx_s;
              stat.brk  <= ~rx_s & allz;
              stat.ovr  <= 1'b0;
              st        <= rx_s ? S_IDLE : S_WAITHI;
            end else cnt <= cnt + 1'b1;
          S_WAITHI: if (rx_s) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  last;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = empty ? last : mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; last <= '0;
    end else begin
      if (do_push) wptr <= step(wptr);
      if (do_pop) begin
        rptr <= step(rptr);
        last <= mem[rptr];
      end
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/serial_rx_stat.sv
module serial_rx_stat
  import serial_rx_pkg::*;
#(
  parameter int CHAN  = 0,
  parameter int DEPTH = 4,
  parameter int OSR   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_tick,
  input  logic        rx_line,
  input  logic        cfg_eight,
  input  logic        cfg_par_en,
  input  logic        cfg_par_odd,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr,
  output logic        rx_avail,
  output logic [7:0]  rd_data,
  output logic        rd_perr,
  output logic        rd_ferr,
  output logic        rd_ovr,
  output logic        rd_brk
);
  localparam logic [7:0] MY_ADDR = chan_addr(CHAN);
  localparam int         CNTW    = $clog2(DEPTH+1);
  localparam int         SW      = $bits(rx_stat_t);

  logic              fr_done;
  logic [DATA_W-1:0] fr_data;
  rx_stat_t          fr_stat;

  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  rx_stat_t          hold_stat;

  logic              push, pop, occupied, ovr_evt, addr_hit;
  logic              d_empty, d_full, s_empty, s_full;
  logic [CNTW-1:0]   d_cnt, s_cnt;
  logic [SW-1:0]     s_out;
  rx_stat_t          out_stat;

  serial_rx_frame #(.OSR(OSR)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_line),
    .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .done(fr_done), .dout(fr_data), .stat(fr_stat)
  );

  assign push     = hold_valid & ~d_full;
  assign occupied = hold_valid & ~push;
  assign ovr_evt  = fr_done & occupied;
  assign addr_hit = (rd_addr == MY_ADDR);
  assign pop      = rd_en & addr_hit & ~d_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0; hold_data <= '0; hold_stat <= '0;
    end else begin
      if (push) hold_valid <= 1'b0;
      if (fr_done) begin
        if (occupied) hold_stat.ovr <= 1'b1;
        else begin
          hold_valid <= 1'b1;
          hold_data  <= fr_data;
          hold_stat  <= fr_stat;
        end
      end
    end
  end

  serial_rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .push(push), .din(hold_data), .pop(pop),
    .dout(rd_data), .empty(d_empty), .full(d_full), .count(d_cnt)
  );

  serial_rx_fifo #(.W(SW), .DEPTH(DEPTH)) u_sq (
    .clk(clk), .rst_n(rst_n), .push(push), .din(hold_stat), .pop(pop),
    .dout(s_out), .empty(s_empty), .full(s_full), .count(s_cnt)
  );

  assign out_stat = rx_stat_t'(s_out);
  assign rx_avail = ~d_empty;
  assign rd_perr  = out_stat.perr;
  assign rd_ferr  = out_stat.ferr;
  assign rd_ovr   = out_stat.ovr;
  assign rd_brk   = out_stat.brk;
endmodule

// File: rtl/serial_rx_stat_chk.sv
module serial_rx_stat_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push,
  input logic                       d_full,
  input logic                       s_empty,
  input logic                       s_full,
  input logic [$clog2(DEPTH+1)-1:0] d_cnt,
  input logic [$clog2(DEPTH+1)-1:0] s_cnt,
  input logic                       ovr_evt,
  input logic                       hold_valid,
  input logic                       hold_ovr,
  input logic                       rd_en,
  input logic                       addr_hit,
  input logic                       rx_avail,
  input logic [7:0]                 rd_data,
  input logic [3:0]                 s_out,
  input logic                       fr_done,
  input logic                       fr_brk,
  input logic                       fr_ferr
);
  localparam int CW = $clog2(DEPTH+1);

  a_r7_lockstep: assert property (@(posedge clk) disable iff (!rst_n)
    d_cnt == s_cnt && s_empty == !rx_avail && s_full == d_full);

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> d_cnt < CW'(DEPTH));

  a_r8_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> hold_valid && hold_ovr);

  a_r6_brk_is_ferr: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && fr_brk |-> fr_ferr);

  a_r9_wrong_addr: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !addr_hit |=> d_cnt == CW'($past(d_cnt) + CW'($past(push))));

  a_r10_empty_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rx_avail && !push |=> $stable(rd_data) && $stable(s_out));
endmodule

bind serial_rx_stat serial_rx_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .d_full(d_full),
  .s_empty(s_empty), .s_full(s_full),
  .d_cnt(d_cnt), .s_cnt(s_cnt), .ovr_evt(ovr_evt), .hold_valid(hold_valid),
  .hold_ovr(hold_stat.ovr), .rd_en(rd_en), .addr_hit(addr_hit),
  .rx_avail(rx_avail), .rd_data(rd_data), .s_out(s_out),
  .fr_done(fr_done), .fr_brk(fr_stat.brk), .fr_ferr(fr_stat.ferr)
);

// File: tb/test_serial_rx_stat.sv
`timescale 1ns/1ps
module test_serial_rx_stat;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic       sample_tick;
  logic       rx_line = 1'b1;
  logic       cfg_eight = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_addr = 8'h08;
  logic       rx_avail, rd_perr, rd_ferr, rd_ovr, rd_brk;
  logic [7:0] rd_data;

  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign sample_tick = (tdiv == 2'd3);

  serial_rx_stat i_serial_rx_stat (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rx_line(rx_line),
    .cfg_eight(cfg_eight), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rd_en(rd_en), .rd_addr(rd_addr), .rx_avail(rx_avail), .rd_data(rd_data),
    .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_ovr(rd_ovr), .rd_brk(rd_brk)
  );

  int   total = 0, bad = 0;
  bit   finished = 0;
  // model entry: {data[7:0], brk, ovr, ferr, perr}
  logic [11:0] q[$];
  logic [11:0] held = '0;
  bit          held_v = 0;
  logic [11:0] last_shown = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expect_entry(input logic [7:0] d, input bit eight,
      input bit pen, input bit podd, input bit pflip, input bit stopv);
    logic [7:0] dm;
    logic pb, brk;
    dm  = eight ? d : {1'b0, d[6:0]};
    pb  = (^dm) ^ podd ^ pflip;
    brk = !stopv && (dm == 8'h00) && (!pen || !pb);
    return {dm, brk, 1'b0, !stopv, pen & pflip};
  endfunction

  task automatic model_add(input logic [11:0] e);
    if (held_v) held[2] = 1'b1;
    else begin held = e; held_v = 1; end
    if (held_v && q.size() < 4) begin q.push_back(held); held_v = 0; end
  endtask

  task automatic bit_time(input logic v);
    rx_line = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit eight, input bit pen,
                      input bit podd, input bit pflip, input bit stopv);
    logic [7:0] dm;
    dm = eight ? d : {1'b0, d[6:0]};
    cfg_eight = eight; cfg_par_en = pen; cfg_par_odd = podd;
    bit_time(1'b0);
    for (int i = 0; i < (eight ? 8 : 7); i++) bit_time(dm[i]);
    if (pen) bit_time((^dm) ^ podd ^ pflip);
    bit_time(stopv);
    bit_time(1'b1);
    bit_time(1'b1);
    model_add(expect_entry(d, eight, pen, podd, pflip, stopv));
  endtask

  task automatic read_chk(input string req, input logic [7:0] addr);
    logic [11:0] exp;
    @(negedge clk);
    exp = (q.size() > 0) ? q[0] : last_shown;
    chk({req, " avail"}, rx_avail, q.size() > 0);
    chk({req, " data"}, rd_data, exp[11:4]);
    chk({req, " status"}, {rd_brk, rd_ovr, rd_ferr, rd_perr}, exp[3:0]);
    rd_addr = addr; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; rd_addr = 8'h08;
    if (addr == 8'h08 && q.size() > 0) begin
      last_shown = q.pop_front();
      if (held_v) begin q.push_back(held); held_v = 0; end
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 avail", rx_avail, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 status", {rd_brk, rd_ovr, rd_ferr, rd_perr}, 0);

    // R2 bit order and widths
    send(8'hA5, 1, 0, 0, 0, 1);
    read_chk("R2 8bit", 8'h08);
    send(8'hFF, 0, 0, 0, 0, 1);
    read_chk("R2 7bit", 8'h08);

    // R3 short glitch ignored
    rx_line = 1'b0; repeat (12) @(negedge clk);
    bit_time(1'b1); bit_time(1'b1);
    chk("R3 glitch", rx_avail, 0);

    // R4 parity both senses, good and bad
    send(8'h3C, 1, 1, 0, 0, 1); read_chk("R4 even ok", 8'h08);
    send(8'h3C, 1, 1, 0, 1, 1); read_chk("R4 even bad", 8'h08);
    send(8'h51, 0, 1, 1, 1, 1); read_chk("R4 odd bad", 8'h08);

    // R5 framing error, then clean recovery
    send(8'h81, 1, 0, 0, 0, 0); read_chk("R5 ferr", 8'h08);
    send(8'h42, 1, 0, 0, 0, 1); read_chk("R5 recover", 8'h08);

    // R6 break
    send(8'h00, 1, 0, 0, 0, 0); read_chk("R6 break", 8'h08);
    send(8'h00, 1, 1, 0, 0, 0); read_chk("R6 break par", 8'h08);

    // R7 R8 six characters with no reads
    for (int i = 0; i < 6; i++) send(8'h10 + 8'(i), 1, 0, 0, 0, 1);
    chk("R7 avail full", rx_avail, 1);
    // R9 wrong address leaves everything alone
    read_chk("R9 wrong addr", 8'h09);
    for (int i = 0; i < 5; i++) read_chk("R7 R8 drain", 8'h08);
    chk("R8 last ovr", {rd_data, rd_ovr}, {8'h14, 1'b1});
    // R10 empty reads keep last value
    read_chk("R10 empty", 8'h08);
    read_chk("R10 empty again", 8'h08);

    // random traffic
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      bit e8, pen, podd, pflip, stopv;
      d     = 8'($urandom);
      e8    = 1'($urandom);
      pen   = 1'($urandom);
      podd  = 1'($urandom);
      pflip = pen && ($urandom_range(0, 7) == 0);
      stopv = ($urandom_range(0, 7) != 0);
      send(d, e8, pen, podd, pflip, stopv);
      if ($urandom_range(0, 2) != 0) read_chk("R2 R4 R5 R7 random", 8'h08);
    end
    while (q.size() > 0 || held_v) read_chk("R7 R8 random drain", 8'h08);
    read_chk("R10 final empty", 8'h08);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule